// File: doc/BRIEF.md
# Double-Buffered Converter Bus Front End

This block is the digital side of a 16-bit voltage-output converter. A 16-bit parallel data bus feeds a first-rank input register. A second-rank converter register holds the code that drives the resistor ladder. Four active-low controls steer the two ranks: an input-register select, a converter-register select, a shared write strobe and a clear. Several converters can be staged one at a time through their input registers and then moved together with one shared converter-select write. Tying the input select low gives single-buffered operation, in which one write carries bus data through both ranks.

The model is synchronous. A system clock samples the controls on each rising edge. While an enable condition holds, the addressed register reloads on every edge, which mirrors a level-sensitive latch. Clear acts at once without a clock, forces the mid-scale code 0000h into both ranks, and is released on the clock. The converter code is given out in two's-complement form and also as a straight-binary ladder code. A one-cycle flag marks each write that changed the converter code.

Top module: `dac_bus_front`

## Requirements
- R1: After a synchronous reset (rst high) the converter code is 0000h, the ladder code is 8000h and the update flag is low. The input register also holds 0000h.
- R2: With in_sel_n low, cv_sel_n high and wr_n low at a rising edge, the input register takes data_i and the converter code stays unchanged.
- R3: With in_sel_n high, cv_sel_n low and wr_n low at a rising edge, the converter code takes the input-register value at that edge.
- R4: With in_sel_n low, cv_sel_n low and wr_n low at a rising edge, both ranks take data_i at that edge, so the converter code equals the bus word.
- R5: With wr_n high, or with both selects high, at a rising edge, neither rank changes and the update flag stays low.
- R6: While clr_n is low, both ranks hold 0000h at once without waiting for a clock, and any write presented at the same time is overridden.
- R7: Writes are ignored at the first two rising edges after clr_n returns high (or after rst falls). A write at the third edge takes effect.
- R8: The ladder code is the converter code with bit 15 inverted: 7FFFh gives FFFFh, 0000h gives 8000h, and 8000h gives 0000h.
- R9: upd_o is high for exactly the one cycle that follows an edge where a write changed the converter code. It stays low when a write reloads the same value, and clear never raises it.
- R10: While a converter-select write is held over several edges, the converter code follows its source on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; controls are sampled on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 16 | Parallel data bus, two's-complement code |
| in_sel_n | input | 1 | Input-register select, active low |
| cv_sel_n | input | 1 | Converter-register select, active low |
| wr_n | input | 1 | Write strobe, active low |
| clr_n | input | 1 | Clear, active low, applied asynchronously |
| cv_code_o | output | 16 | Converter register, two's-complement code |
| ladder_o | output | 16 | Converter code as straight binary for the ladder |
| upd_o | output | 1 | One-cycle pulse after a write that changed the converter code |

## Verification
The hardest case to reach from the ports is the clear-release window. Here clr_n has already risen but the synchronous hold still blocks writes. The bench asserts clr_n in the middle of a cycle while a pass-through write is driven. It checks the zero code before any clock edge arrives. It then keeps the write asserted across the release and expects zero after the first two edges and the bus word after the third. To show that clear also empties the input rank, the bench loads that rank and clears it. It then transfers it with a converter-only write and observes zero at the output.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;
  // Decoded write action for one rising edge
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_LOAD_IN = 2'd1,
    OP_LOAD_CV = 2'd2,
    OP_THRU    = 2'd3
  } dac_op_e;
endpackage

// File: rtl/dacif_ctrl.sv
`timescale 1ns/1ps
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clr_n,
  input  logic    in_sel_n,
  input  logic    cv_sel_n,
  input  logic    wr_n,
  output logic    clr_hold,
  output dac_op_e op
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] hold_sr;

  // Asynchronous set by clear, shifted out on the clock for a synchronous release
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   hold_sr <= '1;
    else if (rst) hold_sr <= '1;
    else          hold_sr <= hold_sr << 1;
  end

  assign clr_hold = hold_sr[MSB];

  always_comb begin
    op = OP_NONE;
    if (!clr_hold && !wr_n) begin
      unique case ({in_sel_n, cv_sel_n})
        2'b01:   op = OP_LOAD_IN;
        2'b10:   op = OP_LOAD_CV;
        2'b00:   op = OP_THRU;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dacif_rank.sv
`timescale 1ns/1ps
module dacif_rank #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         zap,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q <= INIT;
    else if (zap) q <= INIT;
    else if (ld)  q <= d;
  end
endmodule

// File: rtl/dacif_recode.sv
`timescale 1ns/1ps
module dacif_recode #(
  parameter int W       = 16,
  parameter bit TWOS_IN = 1'b1
) (
  input  logic [W-1:0] code,
  output logic [W-1:0] ladder
);
  generate
    if (TWOS_IN) begin : g_twos
      assign ladder = {~code[W-1], code[W-2:0]};
    end else begin : g_straight
      assign ladder = code;
    end
  endgenerate
endmodule

// File: rtl/dacif_chg.sv
`timescale 1ns/1ps
module dacif_chg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         zap,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic [W-1:0] q_now,
  output logic         pulse
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   pulse <= 1'b0;
    else if (zap) pulse <= 1'b0;
    else          pulse <= ld && (d != q_now);
  end
endmodule

// File: rtl/dac_bus_front.sv
`timescale 1ns/1ps
module dac_bus_front
  import dacif_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit TWOS_IN     = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_i,
  input  logic         in_sel_n,
  input  logic         cv_sel_n,
  input  logic         wr_n,
  input  logic         clr_n,
  output logic [W-1:0] cv_code_o,
  output logic [W-1:0] ladder_o,
  output logic         upd_o
);
  localparam logic [W-1:0] CODE_INIT   = '0;
  localparam logic [W-1:0] LADDER_INIT = TWOS_IN ? {1'b1, {(W-1){1'b0}}} : '0;

  logic         clr_hold;
  dac_op_e      op;
  logic         zap;
  logic         in_ld, cv_ld;
  logic [W-1:0] in_q, cv_d, ladder_d;

  dacif_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .clr_n(clr_n),
    .in_sel_n(in_sel_n), .cv_sel_n(cv_sel_n), .wr_n(wr_n),
    .clr_hold(clr_hold), .op(op)
  );

  assign zap   = rst | clr_hold;
  assign in_ld = (op == OP_LOAD_IN) || (op == OP_THRU);
  assign cv_ld = (op == OP_LOAD_CV) || (op == OP_THRU);
  assign cv_d  = (op == OP_THRU) ? data_i : in_q;

  dacif_rank #(.W(W), .INIT(CODE_INIT)) u_in_rank (
    .clk(clk), .clr_n(clr_n), .zap(zap), .ld(in_ld), .d(data_i), .q(in_q)
  );

  dacif_rank #(.W(W), .INIT(CODE_INIT)) u_cv_rank (
    .clk(clk), .clr_n(clr_n), .zap(zap), .ld(cv_ld), .d(cv_d), .q(cv_code_o)
  );

  dacif_recode #(.W(W), .TWOS_IN(TWOS_IN)) u_recode (
    .code(cv_d), .ladder(ladder_d)
  );

  dacif_rank #(.W(W), .INIT(LADDER_INIT)) u_ladder_rank (
    .clk(clk), .clr_n(clr_n), .zap(zap), .ld(cv_ld), .d(ladder_d), .q(ladder_o)
  );

  dacif_chg #(.W(W)) u_chg (
    .clk(clk), .clr_n(clr_n), .zap(zap), .ld(cv_ld),
    .d(cv_d), .q_now(cv_code_o), .pulse(upd_o)
  );
endmodule

// File: rtl/dac_bus_front_chk.sv
`timescale 1ns/1ps
module dac_bus_front_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] data_i,
  input logic         in_sel_n,
  input logic         cv_sel_n,
  input logic         wr_n,
  input logic         clr_n,
  input logic         clr_hold,
  input logic [W-1:0] cv_code_o,
  input logic [W-1:0] ladder_o,
  input logic         upd_o
);
  p_thru_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (!clr_hold && !wr_n && !in_sel_n && !cv_sel_n) |=> (cv_code_o == $past(data_i)));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (wr_n || (in_sel_n && cv_sel_n)) |=> ($stable(cv_code_o) && !upd_o));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (cv_code_o == '0 && !upd_o));

  p_release_hold_r7: assert property (@(posedge clk) disable iff (rst || !clr_n)
    clr_hold |=> ($stable(cv_code_o) && !upd_o));

  p_ladder_msb_r8: assert property (@(posedge clk) disable iff (rst)
    ladder_o == {~cv_code_o[W-1], cv_code_o[W-2:0]});

  p_upd_change_r9: assert property (@(posedge clk) disable iff (rst || !clr_n)
    upd_o |-> (cv_code_o != $past(cv_code_o)));
endmodule

bind dac_bus_front dac_bus_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .data_i(data_i), .in_sel_n(in_sel_n),
  .cv_sel_n(cv_sel_n), .wr_n(wr_n), .clr_n(clr_n), .clr_hold(clr_hold),
  .cv_code_o(cv_code_o), .ladder_o(ladder_o), .upd_o(upd_o)
);

// File: tb/dac_bus_front_bench.sv
`timescale 1ns/1ps
module dac_bus_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] data_i = '0;
  logic        in_sel_n = 1'b1, cv_sel_n = 1'b1, wr_n = 1'b1, clr_n = 1'b1;
  logic [15:0] cv_code_o, ladder_o;
  logic        upd_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dac_bus_front u_dac_bus_front (
    .clk(clk), .rst(rst), .data_i(data_i), .in_sel_n(in_sel_n),
    .cv_sel_n(cv_sel_n), .wr_n(wr_n), .clr_n(clr_n),
    .cv_code_o(cv_code_o), .ladder_o(ladder_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic is, input logic cs, input logic w, input logic [15:0] d);
    in_sel_n = is; cv_sel_n = cs; wr_n = w; data_i = d;
  endtask

  task automatic idle;
    drive(1'b1, 1'b1, 1'b1, data_i);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 code", cv_code_o, 16'h0000);
    chk("R1 ladder", ladder_o, 16'h8000);
    chk("R1 upd", {15'd0, upd_o}, 16'd0);
    rst = 1'b0;
    repeat (3) tick();
    drive(1'b1, 1'b0, 1'b0, 16'h5555);
    tick();
    chk("R1 input rank empty", cv_code_o, 16'h0000);
    idle();
    tick();
  endtask

  task automatic t_staged;
    drive(1'b0, 1'b1, 1'b0, 16'h1A2B);
    tick();
    chk("R2 code unchanged", cv_code_o, 16'h0000);
    chk("R2 no upd", {15'd0, upd_o}, 16'd0);
    idle();
    data_i = 16'hFFFF;
    tick();
    drive(1'b1, 1'b0, 1'b0, 16'h0F0F);
    tick();
    chk("R3 transfer", cv_code_o, 16'h1A2B);
    chk("R9 upd high", {15'd0, upd_o}, 16'd1);
    idle();
    tick();
    chk("R9 upd one cycle", {15'd0, upd_o}, 16'd0);
    drive(1'b1, 1'b0, 1'b0, 16'h0000);
    tick();
    chk("R9 same value no upd", {15'd0, upd_o}, 16'd0);
    idle();
    tick();
  endtask

  task automatic t_hold;
    drive(1'b0, 1'b0, 1'b1, 16'h7777);
    tick();
    chk("R5 wr high", cv_code_o, 16'h1A2B);
    drive(1'b1, 1'b1, 1'b0, 16'h6666);
    tick();
    chk("R5 both selects high", cv_code_o, 16'h1A2B);
    chk("R5 no upd", {15'd0, upd_o}, 16'd0);
    drive(1'b1, 1'b0, 1'b0, 16'h0000);
    tick();
    chk("R5 input rank untouched", cv_code_o, 16'h1A2B);
    idle();
    tick();
  endtask

  task automatic t_thru_ladder;
    drive(1'b0, 1'b0, 1'b0, 16'h7FFF);
    tick();
    chk("R4 thru", cv_code_o, 16'h7FFF);
    chk("R8 ladder full", ladder_o, 16'hFFFF);
    data_i = 16'h8000;
    tick();
    chk("R8 ladder zero", ladder_o, 16'h0000);
    data_i = 16'h0000;
    tick();
    chk("R8 ladder half", ladder_o, 16'h8000);
    idle();
    tick();
  endtask

  task automatic t_follow;
    drive(1'b0, 1'b0, 1'b0, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      data_i = 16'h0101 * (i + 1);
      tick();
      chk("R10 follow", cv_code_o, 16'h0101 * (i + 1));
      chk("R10 upd each", {15'd0, upd_o}, 16'd1);
    end
    idle();
    tick();
  endtask

  task automatic t_clear;
    drive(1'b0, 1'b0, 1'b0, 16'h1234);
    #1 clr_n = 1'b0;
    #0.5;
    chk("R6 async clear", cv_code_o, 16'h0000);
    chk("R6 async ladder", ladder_o, 16'h8000);
    tick();
    chk("R6 clear beats write", cv_code_o, 16'h0000);
    chk("R9 clear no upd", {15'd0, upd_o}, 16'd0);
    clr_n = 1'b1;
    tick();
    chk("R7 edge1 ignored", cv_code_o, 16'h0000);
    tick();
    chk("R7 edge2 ignored", cv_code_o, 16'h0000);
    tick();
    chk("R7 edge3 loads", cv_code_o, 16'h1234);
    drive(1'b0, 1'b1, 1'b0, 16'hBEEF);
    tick();
    idle();
    #1 clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    repeat (3) tick();
    drive(1'b1, 1'b0, 1'b0, 16'h4321);
    tick();
    chk("R6 input rank cleared", cv_code_o, 16'h0000);
    idle();
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_staged();
    t_hold();
    t_thru_ladder();
    t_follow();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule